// File: doc/BRIEF.md
# Dual-Processor Shared RAM Bank Mapper

This block sits between two processors, called A and B, and a shared RAM built as two equal halves. A two-bit mode value chooses which halves each processor reaches through its shared window. The possible assignments are: the whole RAM to one processor, or one half to each processor in either arrangement. A window offset is reduced by masking to the size of whatever is mapped, so the mapped region repeats across the window. When B has no shared RAM mapped, its window accesses land in B's own private RAM. When A has none, its reads return zero and its writes are lost.

Each processor has its own request port. A port carries a write flag, a space select (shared window or register space), an access size of 8, 16 or 32 bits, an address and right-justified write data. Read data returns one cycle after the request, with a valid strobe. The mode lives in a control register. Both processors can read it, each at its own register-space address. Only A can write it. In the default configuration the shared RAM is 1 KiB and the private RAM 2 KiB. A full-size instance sets the shared and private address widths to 15 and 16.

Top module: `shm_bank_mapper`

## Requirements
- R1: After reset the mode is 0, no read-valid strobe is raised, and both processors read the control byte as 0.
- R2: In mode 0, A's window offset is masked to SHARED_AW bits and covers the whole shared RAM. B's window accesses go to its private RAM, with the offset masked to PRIV_AW bits.
- R3: In mode 1, A reaches the upper half and B the lower half. In mode 2, A reaches the lower half and B the upper half. In both modes each offset is masked to SHARED_AW-1 bits.
- R4: In mode 3, B's window offset is masked to SHARED_AW bits and covers the whole shared RAM. A's window reads return 0 and A's window writes change nothing.
- R5: The mode register is one byte at CTL_ADDR_A in A's register space (space=1), and its low two bits hold the mode. A write of any size whose byte lanes cover that byte sets the mode from bits [1:0] of that byte, and the new mode applies from the next cycle on. B reads the same value at CTL_ADDR_B. B's register writes are ignored. Any other register-space byte reads as 0.
- R6: The size code is 0 for 8 bits, 1 for 16 bits and 2 or 3 for 32 bits. Before masking, the address is aligned down to the size by clearing bit 0 (16-bit) or bits 1:0 (32-bit). Bytes are little-endian. A write takes its data from the low bits of the write-data port. A read returns its data right-justified and zero-extended.
- R7: A read request raises that port's rvalid in the next cycle, with its data. A write or idle cycle leaves rvalid low in the next cycle.
- R8: A and B are served in the same cycle with no stall. In no mode do both reach the same half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | A: access request this cycle |
| a_we | input | 1 | A: 1 = write, 0 = read |
| a_space | input | 1 | A: 0 = shared window, 1 = register space |
| a_size | input | 2 | A: 0 byte, 1 half, 2/3 word |
| a_addr | input | ADDR_W | A: byte address |
| a_wdata | input | 32 | A: right-justified write data |
| a_rvalid | output | 1 | A: read data valid |
| a_rdata | output | 32 | A: right-justified read data |
| b_req | input | 1 | B: access request this cycle |
| b_we | input | 1 | B: 1 = write, 0 = read |
| b_space | input | 1 | B: 0 = shared window, 1 = register space |
| b_size | input | 2 | B: 0 byte, 1 half, 2/3 word |
| b_addr | input | ADDR_W | B: byte address |
| b_wdata | input | 32 | B: right-justified write data |
| b_rvalid | output | 1 | B: read data valid |
| b_rdata | output | 32 | B: right-justified read data |

## Verification
The bench builds the block with a 64-byte shared RAM, a 128-byte private RAM and 12-bit addresses. At that size, one sweep of 128 window addresses per mode runs through every wrap of both the 32-byte and the 64-byte masks, and also fills the whole private RAM. With the RAMs this small, every mode can be swept exhaustively at every access size and every alignment, with both processors active in every cycle. A pseudo-random phase then mixes writes of all sizes, mode changes and register-space accesses, including writes from B to the control byte.

// File: rtl/shm_pkg.sv
package shm_pkg;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_LO   = 3'd1,
        TGT_HI   = 3'd2,
        TGT_PRIV = 3'd3,
        TGT_CTL  = 3'd4
    } tgt_e;

    // clear the low address bits covered by the access size
    function automatic logic [1:0] align_low(input logic [1:0] lo, input logic [1:0] size);
        case (size)
            2'd0:    return lo;
            2'd1:    return {lo[1], 1'b0};
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [3:0] lane_be(input logic [1:0] size, input logic [1:0] off);
        case (size)
            2'd0:    return 4'b0001 << off;
            2'd1:    return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] lane_wdata(input logic [1:0] size, input logic [31:0] wd);
        case (size)
            2'd0:    return {4{wd[7:0]}};
            2'd1:    return {2{wd[15:0]}};
            default: return wd;
        endcase
    endfunction

    function automatic logic [31:0] lane_rdata(input logic [1:0] size, input logic [1:0] off,
                                               input logic [31:0] word);
        logic [31:0] sh;
        sh = word >> {off, 3'b000};
        case (size)
            2'd0:    return {24'd0, sh[7:0]};
            2'd1:    return {16'd0, sh[15:0]};
            default: return sh;
        endcase
    endfunction

endpackage

// File: rtl/shm_route.sv
module shm_route
    import shm_pkg::*;
#(
    parameter bit IS_A      = 1'b1,
    parameter int LOW_W     = 10,
    parameter int SHARED_AW = 10,
    parameter int PRIV_AW   = 11,
    parameter int IW        = 7
) (
    input  logic [1:0]       mode,
    input  logic             space,
    input  logic [1:0]       size,
    input  logic [LOW_W-1:0] addr,
    output tgt_e             tgt,
    output logic [IW-1:0]    widx,
    output logic [1:0]       off
);
    logic [LOW_W-1:0] al;
    logic [IW-1:0]    half_idx;

    always_comb begin
        al       = {addr[LOW_W-1:2], align_low(addr[1:0], size)};
        half_idx = IW'(al[SHARED_AW-2:2]);
    end

    assign off = al[1:0];

    generate
        if (IS_A) begin : g_side_a
            always_comb begin
                widx = half_idx;
                if (space) begin
                    tgt  = TGT_CTL;
                    widx = '0;
                end else begin
                    case (mode)
                        2'd0:    tgt = al[SHARED_AW-1] ? TGT_HI : TGT_LO;
                        2'd1:    tgt = TGT_HI;
                        2'd2:    tgt = TGT_LO;
                        default: tgt = TGT_NONE;
                    endcase
                end
            end
        end else begin : g_side_b
            always_comb begin
                widx = half_idx;
                if (space) begin
                    tgt  = TGT_CTL;
                    widx = '0;
                end else begin
                    case (mode)
                        2'd0: begin
                            tgt  = TGT_PRIV;
                            widx = IW'(al[PRIV_AW-1:2]);
                        end
                        2'd1:    tgt = TGT_LO;
                        2'd2:    tgt = TGT_HI;
                        default: tgt = al[SHARED_AW-1] ? TGT_HI : TGT_LO;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/shm_ram.sv
module shm_ram #(
    parameter int DEPTH = 128,
    parameter int DW    = 7
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [3:0]    be,
    input  logic [DW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    generate
        for (genvar l = 0; l < 4; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (en && we && be[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (en && !we) rdata <= mem[idx];
    end

endmodule

// File: rtl/shm_bank_mapper.sv
module shm_bank_mapper
    import shm_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter int              SHARED_AW  = 10,
    parameter int              PRIV_AW    = 11,
    parameter logic [ADDR_W-1:0] CTL_ADDR_A = 16'h012B,
    parameter logic [ADDR_W-1:0] CTL_ADDR_B = 16'h00C5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic              a_space,
    input  logic [1:0]        a_size,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [31:0]       a_wdata,
    output logic              a_rvalid,
    output logic [31:0]       a_rdata,
    input  logic              b_req,
    input  logic              b_we,
    input  logic              b_space,
    input  logic [1:0]        b_size,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [31:0]       b_wdata,
    output logic              b_rvalid,
    output logic [31:0]       b_rdata
);
    localparam int HW       = SHARED_AW - 3;
    localparam int PW       = PRIV_AW - 2;
    localparam int IWB      = (PW > HW) ? PW : HW;
    localparam int LOW_B    = (PRIV_AW > SHARED_AW) ? PRIV_AW : SHARED_AW;
    localparam int HALF_WDS = 2 ** HW;
    localparam int PRIV_WDS = 2 ** PW;
    localparam int LA       = int'(CTL_ADDR_A[1:0]);
    localparam int LB       = int'(CTL_ADDR_B[1:0]);

    typedef struct packed {
        logic [1:0]  mode;
        logic        a_v;
        tgt_e        a_t;
        logic [1:0]  a_o;
        logic [1:0]  a_s;
        logic [31:0] a_reg;
        logic        b_v;
        tgt_e        b_t;
        logic [1:0]  b_o;
        logic [1:0]  b_s;
        logic [31:0] b_reg;
    } state_t;

    state_t st_d, st_q;

    tgt_e            a_tgt, b_tgt;
    logic [HW-1:0]   a_widx;
    logic [IWB-1:0]  b_widx;
    logic [1:0]      a_off, b_off;
    logic [3:0]      a_be, b_be;
    logic [31:0]     a_wl, b_wl;
    logic [1:0]      mode_now;

    logic            bank_en [2];
    logic            bank_we [2];
    logic [3:0]      bank_be [2];
    logic [HW-1:0]   bank_idx [2];
    logic [31:0]     bank_wd [2];
    logic [31:0]     bank_rd [2];
    logic            priv_en;
    logic [31:0]     priv_rd;
    logic [31:0]     a_word, b_word;

    assign mode_now = st_q.mode;

    shm_route #(
        .IS_A(1'b1), .LOW_W(SHARED_AW), .SHARED_AW(SHARED_AW),
        .PRIV_AW(PRIV_AW), .IW(HW)
    ) u_route_a (
        .mode(st_q.mode), .space(a_space), .size(a_size),
        .addr(a_addr[SHARED_AW-1:0]), .tgt(a_tgt), .widx(a_widx), .off(a_off)
    );

    shm_route #(
        .IS_A(1'b0), .LOW_W(LOW_B), .SHARED_AW(SHARED_AW),
        .PRIV_AW(PRIV_AW), .IW(IWB)
    ) u_route_b (
        .mode(st_q.mode), .space(b_space), .size(b_size),
        .addr(b_addr[LOW_B-1:0]), .tgt(b_tgt), .widx(b_widx), .off(b_off)
    );

    always_comb begin
        a_be = lane_be(a_size, a_off);
        b_be = lane_be(b_size, b_off);
        a_wl = lane_wdata(a_size, a_wdata);
        b_wl = lane_wdata(b_size, b_wdata);
    end

    // one bank per half; A takes the port whenever it targets the half
    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            localparam tgt_e MY_T = (h == 0) ? TGT_LO : TGT_HI;
            logic sel_a, sel_b;
            assign sel_a       = a_req && (a_tgt == MY_T);
            assign sel_b       = b_req && (b_tgt == MY_T);
            assign bank_en[h]  = sel_a || sel_b;
            assign bank_we[h]  = sel_a ? a_we : b_we;
            assign bank_be[h]  = sel_a ? a_be : b_be;
            assign bank_idx[h] = sel_a ? a_widx : b_widx[HW-1:0];
            assign bank_wd[h]  = sel_a ? a_wl : b_wl;

            shm_ram #(.DEPTH(HALF_WDS), .DW(HW)) u_bank (
                .clk(clk), .en(bank_en[h]), .we(bank_we[h]), .be(bank_be[h]),
                .idx(bank_idx[h]), .wdata(bank_wd[h]), .rdata(bank_rd[h])
            );
        end
    endgenerate

    assign priv_en = b_req && (b_tgt == TGT_PRIV);

    shm_ram #(.DEPTH(PRIV_WDS), .DW(PW)) u_priv (
        .clk(clk), .en(priv_en), .we(b_we), .be(b_be),
        .idx(b_widx[PW-1:0]), .wdata(b_wl), .rdata(priv_rd)
    );

    // next-state logic: control register and per-port read pipeline
    always_comb begin
        st_d = st_q;

        st_d.a_v   = a_req && !a_we;
        st_d.a_t   = a_tgt;
        st_d.a_o   = a_off;
        st_d.a_s   = a_size;
        st_d.a_reg = (a_addr[ADDR_W-1:2] == CTL_ADDR_A[ADDR_W-1:2])
                   ? (32'(st_q.mode) << (8 * LA)) : 32'd0;

        st_d.b_v   = b_req && !b_we;
        st_d.b_t   = b_tgt;
        st_d.b_o   = b_off;
        st_d.b_s   = b_size;
        st_d.b_reg = (b_addr[ADDR_W-1:2] == CTL_ADDR_B[ADDR_W-1:2])
                   ? (32'(st_q.mode) << (8 * LB)) : 32'd0;

        if (a_req && a_we && (a_tgt == TGT_CTL)
            && (a_addr[ADDR_W-1:2] == CTL_ADDR_A[ADDR_W-1:2]) && a_be[LA])
            st_d.mode = a_wl[8*LA +: 2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read return path
    always_comb begin
        case (st_q.a_t)
            TGT_LO:  a_word = bank_rd[0];
            TGT_HI:  a_word = bank_rd[1];
            TGT_CTL: a_word = st_q.a_reg;
            default: a_word = 32'd0;
        endcase
        case (st_q.b_t)
            TGT_LO:   b_word = bank_rd[0];
            TGT_HI:   b_word = bank_rd[1];
            TGT_PRIV: b_word = priv_rd;
            TGT_CTL:  b_word = st_q.b_reg;
            default:  b_word = 32'd0;
        endcase
        a_rvalid = st_q.a_v;
        b_rvalid = st_q.b_v;
        a_rdata  = lane_rdata(st_q.a_s, st_q.a_o, a_word);
        b_rdata  = lane_rdata(st_q.b_s, st_q.b_o, b_word);
    end

endmodule

module shm_chk
    import shm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        a_req,
    input logic        a_we,
    input logic        a_space,
    input logic        a_rvalid,
    input logic [31:0] a_rdata,
    input logic        b_req,
    input logic        b_we,
    input logic        b_rvalid,
    input logic [1:0]  mode,
    input logic [2:0]  a_tgt,
    input logic [2:0]  b_tgt
);
    AST_A_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !a_we) |=> a_rvalid);                                   // R7
    AST_A_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_req && !a_we) |=> !a_rvalid);                                 // R7
    AST_B_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !b_we) |=> b_rvalid);                                   // R7
    AST_B_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_req && !b_we) |=> !b_rvalid);                                 // R7
    AST_HALVES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && b_req && (a_tgt == TGT_LO || a_tgt == TGT_HI)) |-> (a_tgt != b_tgt)); // R8
    AST_MODE_WRITER_A: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> $past(a_req && a_we && a_space));              // R5
    AST_A_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !a_we && !a_space && mode == 2'd3) |=> (a_rdata == 32'd0)); // R4
endmodule

bind shm_bank_mapper shm_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_we(a_we), .a_space(a_space),
    .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .b_req(b_req), .b_we(b_we), .b_rvalid(b_rvalid),
    .mode(mode_now), .a_tgt(a_tgt), .b_tgt(b_tgt)
);

// File: tb/sim_shm_bank_mapper.sv
module sim_shm_bank_mapper;
    localparam int AW  = 12;
    localparam int SH  = 64;
    localparam int HF  = 32;
    localparam int PR  = 128;
    localparam int CTA = 'h12B;
    localparam int CTB = 'h0C5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_req = 0, a_we = 0, a_space = 0;
    logic [1:0]    a_size = 0;
    logic [AW-1:0] a_addr = 0;
    logic [31:0]   a_wdata = 0;
    logic          a_rvalid;
    logic [31:0]   a_rdata;
    logic          b_req = 0, b_we = 0, b_space = 0;
    logic [1:0]    b_size = 0;
    logic [AW-1:0] b_addr = 0;
    logic [31:0]   b_wdata = 0;
    logic          b_rvalid;
    logic [31:0]   b_rdata;

    always #5 clk = ~clk;

    shm_bank_mapper #(
        .ADDR_W(AW), .SHARED_AW(6), .PRIV_AW(7),
        .CTL_ADDR_A(12'h12B), .CTL_ADDR_B(12'h0C5)
    ) u0 (.*);

    int checks = 0;
    int fails  = 0;
    logic [7:0] sh_m [SH];
    logic [7:0] pr_m [PR];
    int mode_m = 0;
    bit ea_v = 0, eb_v = 0;
    logic [31:0] ea_d = 0, eb_d = 0;
    string ta = "", tb_ = "";

    // kind: 0 unmapped, 1 shared, 2 private, 3 register
    function automatic int mapk(bit isa, int md, bit sp, int sz, int addr, output int ba);
        int al;
        al = addr & ~((1 << sz) - 1);
        ba = al;
        if (sp) return 3;
        if (isa) begin
            case (md)
                0: begin ba = al % SH; return 1; end
                1: begin ba = HF + al % HF; return 1; end
                2: begin ba = al % HF; return 1; end
                default: return 0;
            endcase
        end else begin
            case (md)
                0: begin ba = al % PR; return 2; end
                1: begin ba = al % HF; return 1; end
                2: begin ba = HF + al % HF; return 1; end
                default: begin ba = al % SH; return 1; end
            endcase
        end
    endfunction

    function automatic logic [31:0] rd_model(bit isa, bit sp, int sz, int addr);
        int ba, k, n;
        logic [31:0] v;
        logic [7:0] by;
        v = 0;
        n = 1 << sz;
        k = mapk(isa, mode_m, sp, sz, addr, ba);
        for (int i = 0; i < n; i++) begin
            case (k)
                1: by = sh_m[ba + i];
                2: by = pr_m[ba + i];
                3: by = ((ba + i) == (isa ? CTA : CTB)) ? 8'(mode_m) : 8'd0;
                default: by = 8'd0;
            endcase
            v = v | (32'(by) << (8 * i));
        end
        return v;
    endfunction

    task automatic wr_model(bit isa, bit sp, int sz, int addr, logic [31:0] wd, inout int newmode);
        int ba, k, n;
        n = 1 << sz;
        k = mapk(isa, mode_m, sp, sz, addr, ba);
        for (int i = 0; i < n; i++) begin
            logic [7:0] by;
            by = 8'(wd >> (8 * i));
            case (k)
                1: sh_m[ba + i] = by;
                2: pr_m[ba + i] = by;
                3: if (isa && (ba + i) == CTA) newmode = int'(by[1:0]);
                default: ;
            endcase
        end
    endtask

    task automatic check_prev();
        checks++;
        if (a_rvalid !== ea_v || (ea_v && a_rdata !== ea_d)) begin
            fails++;
            $display("FAIL %s port A: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     ta, a_rvalid, a_rdata, ea_v, ea_d);
        end
        checks++;
        if (b_rvalid !== eb_v || (eb_v && b_rdata !== eb_d)) begin
            fails++;
            $display("FAIL %s port B: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tb_, b_rvalid, b_rdata, eb_v, eb_d);
        end
    endtask

    task automatic step(bit ar, bit aw, bit as_, int asz, int aad, logic [31:0] awd, string tga,
                        bit br, bit bw, bit bs_, int bsz, int bad, logic [31:0] bwd, string tgb);
        int nm;
        @(negedge clk);
        check_prev();
        a_req = ar; a_we = aw; a_space = as_; a_size = 2'(asz); a_addr = AW'(aad); a_wdata = awd;
        b_req = br; b_we = bw; b_space = bs_; b_size = 2'(bsz); b_addr = AW'(bad); b_wdata = bwd;
        ea_v = ar && !aw;
        eb_v = br && !bw;
        ea_d = ea_v ? rd_model(1'b1, as_, asz, aad) : 32'd0;
        eb_d = eb_v ? rd_model(1'b0, bs_, bsz, bad) : 32'd0;
        ta = tga;
        tb_ = tgb;
        nm = mode_m;
        if (ar && aw) wr_model(1'b1, as_, asz, aad, awd, nm);
        if (br && bw) wr_model(1'b0, bs_, bsz, bad, bwd, nm);
        mode_m = nm;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, "R7", 0, 0, 0, 0, 0, 0, "R7");
    endtask

    function automatic string mtag(int md);
        return (md == 0) ? "R2" : (md == 3) ? "R4" : "R3";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        for (int i = 0; i < SH; i++) sh_m[i] = 0;
        for (int i = 0; i < PR; i++) pr_m[i] = 0;
        repeat (3) @(negedge clk);
        // R1: no valid strobe while in reset
        checks++;
        if (a_rvalid !== 1'b0 || b_rvalid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: rvalid a=%0b b=%0b expected 0 0", a_rvalid, b_rvalid);
        end
        rst_n = 1'b1;
        // R1: control byte reads 0 from both sides after reset
        step(1, 0, 1, 0, CTA, 0, "R1", 1, 0, 1, 0, CTB, 0, "R1");
        idle();

        for (int md = 0; md < 4; md++) begin
            // R5: byte write with upper bits set; only bits [1:0] count
            step(1, 1, 1, 0, CTA, 32'(md | 'hFC), "R5", 0, 0, 0, 0, 0, 0, "R5");
            // R5/R6: both sides read the register via word-wide reads
            step(1, 0, 1, 2, CTA, 0, "R5", 1, 0, 1, 2, CTB, 0, "R5");
            step(1, 0, 1, 0, CTA, 0, "R5", 1, 0, 1, 1, CTB, 0, "R5");
            // fill through the whole window, both processors in the same cycle (R8)
            for (int ad = 0; ad < PR; ad++)
                step(1, 1, 0, 0, ad, 32'((ad * 7 + md * 13 + 1) & 'hFF), mtag(md),
                     1, 1, 0, 0, ad, 32'((ad * 11 + md * 5 + 3) & 'hFF), mtag(md));
            // read back every address at every size (R6 alignment and lanes)
            for (int sz = 0; sz < 3; sz++)
                for (int ad = 0; ad < PR; ad++)
                    step(1, 0, 0, sz, ad, 0, mtag(md), 1, 0, 0, sz, ad, 0, mtag(md));
        end

        // R5: writes from B to the register space are ignored
        step(1, 1, 1, 0, CTA, 32'h1, "R5", 0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, "R5", 1, 1, 1, 0, CTB, 32'h3, "R5");
        step(0, 0, 0, 0, 0, 0, "R5", 1, 1, 1, 0, CTA, 32'h2, "R5");
        step(1, 0, 1, 0, CTA, 0, "R5", 1, 0, 1, 0, CTB, 0, "R5");
        // R5: a word write covering the control byte sets the mode
        step(1, 1, 1, 2, CTA & ~3, 32'h0000_0200, "R5", 0, 0, 0, 0, 0, 0, "R5");
        step(1, 0, 1, 0, CTA, 0, "R5", 1, 0, 1, 0, CTB + 1, 0, "R5");

        // mixed pseudo-random traffic (R6 sizes, mode changes, R8 concurrency)
        seed = 32'h1357_9BDF;
        for (int n = 0; n < 3000; n++) begin
            int unsigned r1, r2, r3;
            bit a_reg_op, b_reg_op;
            seed = seed * 1103515245 + 12345; r1 = seed >> 8;
            seed = seed * 1103515245 + 12345; r2 = seed >> 8;
            seed = seed * 1103515245 + 12345; r3 = seed;
            a_reg_op = (r1 % 23) == 0;
            b_reg_op = (r2 % 19) == 0;
            step(1, r1[20], a_reg_op, int'(r1[3:2]) % 3,
                 a_reg_op ? CTA - 1 + int'(r1[6:5]) : int'(r1[15:8]), r3, "R6",
                 r2[21], r2[20], b_reg_op, int'(r2[3:2]) % 3,
                 b_reg_op ? CTB - 1 + int'(r2[6:5]) : int'(r2[15:8]), ~r3, "R6");
        end
        idle();
        idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule